// File: doc/BRIEF.md
# Coin-Operated Vending Controller

This block is the sequencing core of a five-item vending machine. A 3-bit selection code chooses the item, and three one-cycle pulse inputs report accepted coins of 25, 10 and 5 cents. The controller adds the coins to a running total and shows the item's price and the money paid as plain binary cent values, ready for a separate display stage. When the total meets or exceeds the price, it fires a one-cycle dispense pulse. It then shows the change for a fixed number of cycles and clears itself for the next customer.

Internally, every amount is counted in units of five cents. The item chosen at the first coin is held until the sale ends, so the customer cannot change it partway through. An active-high asynchronous reset returns the block to idle at any moment, without waiting for a clock edge. Coin debouncing, display decoding and the dispensing mechanism belong to neighbouring blocks.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is held and after its release, price display aside, `paid_cents`, `change_cents`, `change_valid` and `dispense` are all zero.
- R2: Selection codes 0, 1, 2, 3 and 4 price the item at 55, 60, 65, 70 and 75 cents. Codes 5 to 7 are not items: `price_cents` reads 0, and a coin pulse in idle with such a code leaves `paid_cents` at 0.
- R3: `coin_25`, `coin_10` and `coin_5` add 25, 10 and 5 cents. The new total appears on `paid_cents` in the cycle after the clock edge that sampled the pulse.
- R4: When several coin pulses are high in the same cycle, only the one with the highest value is credited.
- R5: The first accepted coin latches the selection. Until the sale ends, `price_cents` shows the latched price whatever `sel` does.
- R6: On the edge where the total reaches or passes the price, `dispense` rises. It stays high for exactly one cycle.
- R7: In the cycle after `dispense`, `change_valid` rises and stays high for exactly 4 cycles. During those cycles `change_cents` equals the paid total minus the price.
- R8: Coin pulses during dispense and change display are ignored, so `paid_cents` holds. After the change display the block is idle with `paid_cents` equal to 0 and accepts a new sale.
- R9: Raising `rst` clears the total and the outputs at once, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| sel | input | 3 | Item selection code |
| coin_25 | input | 1 | One-cycle pulse for a 25-cent coin |
| coin_10 | input | 1 | One-cycle pulse for a 10-cent coin |
| coin_5 | input | 1 | One-cycle pulse for a 5-cent coin |
| price_cents | output | 8 | Price of the selected or latched item, in cents |
| paid_cents | output | 8 | Money inserted so far, in cents |
| change_cents | output | 8 | Change owed, valid with `change_valid` |
| change_valid | output | 1 | High while the change is displayed |
| dispense | output | 1 | One-cycle release pulse |

## Verification
The bound checker runs on every cycle and checks the following:
- the dispense pulse lasts one cycle and is never issued underpaid;
- the change window follows the pulse, lasts exactly four cycles and carries paid minus price;
- the price stays frozen while money is held;
- the total is zero once the window closes.

Several behaviours only the bench's scenarios can show:
- the item price table;
- the coin values and the choice of the highest coin among simultaneous pulses;
- rejection of invalid codes;
- the clearing effect of reset between clock edges.

The bench covers these with a sweep over every item and every coin pattern.

// File: rtl/vend_pkg.sv
package vend_pkg;
    localparam int NUM_ITEMS    = 5;
    localparam int SEL_W        = 3;
    localparam int UNIT_W       = 5;
    localparam int CENT_W       = 8;
    localparam int CENTS_PER_U  = 5;
    localparam int BASE_PRICE_U = 11;
    localparam int PRICE_STEP_U = 1;
    localparam int NUM_COINS    = 3;

    typedef logic [UNIT_W-1:0] units_t;
    typedef logic [CENT_W-1:0] cents_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DISPENSE,
        ST_SHOW
    } vend_state_e;

    typedef struct packed {
        logic   valid;
        units_t value;
    } coin_t;

    // coin values in units, index 0 has the highest priority
    function automatic units_t coin_units(input int idx);
        case (idx)
            0:       return units_t'(5);
            1:       return units_t'(2);
            default: return units_t'(1);
        endcase
    endfunction

    function automatic units_t price_of(input logic [SEL_W-1:0] code);
        if (int'(code) < NUM_ITEMS)
            return units_t'(BASE_PRICE_U + int'(code) * PRICE_STEP_U);
        return '0;
    endfunction

    function automatic cents_t to_cents(input units_t u);
        return cents_t'(int'(u) * CENTS_PER_U);
    endfunction
endpackage

// File: rtl/vend_coin_pick.sv
module vend_coin_pick
    import vend_pkg::*;
(
    input  logic [NUM_COINS-1:0] pulses,
    output coin_t                coin
);
    always_comb begin
        coin = '0;
        for (int i = NUM_COINS - 1; i >= 0; i--) begin
            if (pulses[i]) begin
                coin.valid = 1'b1;
                coin.value = coin_units(i);
            end
        end
    end
endmodule

// File: rtl/vend_purse.sv
module vend_purse
    import vend_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  vend_state_e      state,
    input  logic             clear,
    input  coin_t            coin,
    input  logic [SEL_W-1:0] sel,
    output units_t           total,
    output units_t           price,
    output logic             accept,
    output logic             reach
);
    logic [SEL_W-1:0] sel_lat;
    units_t           sum;
    logic             idle;

    assign idle   = (state == ST_IDLE);
    assign price  = idle ? price_of(sel) : price_of(sel_lat);
    assign accept = coin.valid &&
                    ((idle && price_of(sel) != '0) || state == ST_COLLECT);
    assign sum    = idle ? coin.value : units_t'(total + coin.value);
    assign reach  = accept && (sum >= price);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            total   <= '0;
            sel_lat <= '0;
        end else if (clear) begin
            total   <= '0;
        end else if (accept) begin
            total <= sum;
            if (idle) sel_lat <= sel;
        end
    end
endmodule

// File: rtl/vend_fsm.sv
module vend_fsm
    import vend_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        accept,
    input  logic        reach,
    output vend_state_e state,
    output logic        clear
);
    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    logic [CNT_W-1:0] cnt;

    assign clear = (state == ST_SHOW) && (cnt == LAST);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE:     if (accept) state <= reach ? ST_DISPENSE : ST_COLLECT;
                ST_COLLECT:  if (reach) state <= ST_DISPENSE;
                ST_DISPENSE: begin
                    state <= ST_SHOW;
                    cnt   <= '0;
                end
                default: begin
                    if (cnt == LAST) state <= ST_IDLE;
                    else             cnt   <= cnt + 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
    import vend_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             coin_25,
    input  logic             coin_10,
    input  logic             coin_5,
    output logic [CENT_W-1:0] price_cents,
    output logic [CENT_W-1:0] paid_cents,
    output logic [CENT_W-1:0] change_cents,
    output logic             change_valid,
    output logic             dispense
);
    coin_t       coin;
    vend_state_e state;
    logic        clear, accept, reach;
    units_t      total, price;

    vend_coin_pick u_pick (
        .pulses ({coin_5, coin_10, coin_25}),
        .coin   (coin)
    );

    vend_purse u_purse (
        .clk    (clk),
        .rst    (rst),
        .state  (state),
        .clear  (clear),
        .coin   (coin),
        .sel    (sel),
        .total  (total),
        .price  (price),
        .accept (accept),
        .reach  (reach)
    );

    vend_fsm #(.HOLD_CYC(HOLD_CYC)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .reach  (reach),
        .state  (state),
        .clear  (clear)
    );

    assign price_cents  = to_cents(price);
    assign paid_cents   = to_cents(total);
    assign change_valid = (state == ST_SHOW);
    assign dispense     = (state == ST_DISPENSE);
    assign change_cents = change_valid ? to_cents(units_t'(total - price)) : '0;
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk
    import vend_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [CENT_W-1:0] price_cents,
    input logic [CENT_W-1:0] paid_cents,
    input logic [CENT_W-1:0] change_cents,
    input logic              change_valid,
    input logic              dispense
);
    int run;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) run <= 0;
        else     run <= change_valid ? run + 1 : 0;
    end

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        dispense |=> !dispense);

    p_paid_enough_r6: assert property (@(posedge clk) disable iff (rst)
        dispense |-> (paid_cents >= price_cents));

    p_window_follows_r7: assert property (@(posedge clk) disable iff (rst)
        dispense |=> change_valid);

    p_window_cap_r7: assert property (@(posedge clk) disable iff (rst)
        (run >= HOLD_CYC) |-> !change_valid);

    p_window_len_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(change_valid) |-> (run == HOLD_CYC));

    p_change_amt_r7: assert property (@(posedge clk) disable iff (rst)
        change_valid |-> (change_cents + price_cents == paid_cents));

    p_price_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (paid_cents != 0 && $past(paid_cents) != 0) |-> $stable(price_cents));

    p_cleared_after_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(change_valid) |-> (paid_cents == 0));
endmodule

bind vend_ctrl vend_ctrl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (.*);

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic       coin_25 = 1'b0, coin_10 = 1'b0, coin_5 = 1'b0;
    logic [7:0] price_cents, paid_cents, change_cents;
    logic       change_valid, dispense;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    vend_ctrl dut (
        .clk(clk), .rst(rst), .sel(sel),
        .coin_25(coin_25), .coin_10(coin_10), .coin_5(coin_5),
        .price_cents(price_cents), .paid_cents(paid_cents),
        .change_cents(change_cents), .change_valid(change_valid),
        .dispense(dispense)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // mode 0/1/2: one coin kind; 3: rotating; 4: all three at once (R4); 5: dime+nickel (R4)
    task automatic sale(input int p, input int mode);
        int tot = 0;
        int pr  = 55 + 5 * p;
        int i   = 0;
        sel = 3'(p);
        while (tot < pr) begin
            int kind = (mode == 3) ? (i % 3) : mode;
            int val;
            case (kind)
                0: begin coin_25 = 1; val = 25; end
                1: begin coin_10 = 1; val = 10; end
                2: begin coin_5  = 1; val = 5;  end
                4: begin coin_25 = 1; coin_10 = 1; coin_5 = 1; val = 25; end
                default: begin coin_10 = 1; coin_5 = 1; val = 10; end
            endcase
            tick();
            coin_25 = 0; coin_10 = 0; coin_5 = 0;
            tot += val;
            chk((mode >= 4) ? "R4 highest coin credited" : "R3 paid total", int'(paid_cents), tot);
            chk("R2 price of item", int'(price_cents), pr);
            if (tot < pr) begin
                chk("R6 no early dispense", int'(dispense), 0);
                if (i % 2 == 0) begin
                    sel = 3'((p + 1) % 5);
                    tick();
                    chk("R5 price latched", int'(price_cents), pr);
                    chk("R3 total holds without coin", int'(paid_cents), tot);
                    sel = 3'(p);
                end
            end
            i++;
        end
        chk("R6 dispense on reach", int'(dispense), 1);
        chk("R7 no change yet", int'(change_valid), 0);
        coin_25 = 1;
        sel = 3'((p + 2) % 5);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R7 change window", int'(change_valid), 1);
            chk("R7 change amount", int'(change_cents), tot - pr);
            chk("R6 single pulse", int'(dispense), 0);
            chk("R8 coins ignored", int'(paid_cents), tot);
            chk("R5 price held", int'(price_cents), pr);
        end
        coin_25 = 0;
        sel = 3'(p);
        tick();
        chk("R7 window closed", int'(change_valid), 0);
        chk("R8 back to idle", int'(paid_cents), 0);
    endtask

    initial begin
        #1;
        chk("R1 paid in reset", int'(paid_cents), 0);
        chk("R1 dispense in reset", int'(dispense), 0);
        chk("R1 change flag in reset", int'(change_valid), 0);
        tick(); tick();
        rst = 0;
        tick();
        chk("R1 paid after reset", int'(paid_cents), 0);
        chk("R1 change after reset", int'(change_cents), 0);

        for (int s = 5; s < 8; s++) begin
            sel = 3'(s);
            coin_25 = 1;
            tick();
            coin_25 = 0;
            chk("R2 invalid code price", int'(price_cents), 0);
            chk("R2 invalid code ignores coin", int'(paid_cents), 0);
        end

        for (int p = 0; p < 5; p++)
            for (int m = 0; m < 6; m++)
                sale(p, m);

        // R9: async clear mid-sale
        sel = 3'd4;
        coin_10 = 1;
        tick();
        coin_10 = 0;
        chk("R9 precondition", int'(paid_cents), 10);
        #2 rst = 1;
        #1;
        chk("R9 async clear", int'(paid_cents), 0);
        chk("R9 async no change flag", int'(change_valid), 0);
        tick();
        rst = 0;
        tick();
        sale(2, 3);
        finish_run();
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule